// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous SRAM. It drives the memory's active-high reset pin and its PLL-enable pin through the start-up order the memory needs. First it holds the memory in reset, optionally for a programmable one-millisecond pulse, until the system reports that the clocks are stable. It then releases reset and waits through a fixed calibration window. After that it waits through a fixed PLL lock window. Only then does it raise a ready flag, which the surrounding controller uses to permit reads and writes.

The PLL pin can be raised at one of two points, chosen by an input. In the early ordering it rises together with the reset release, so the lock wait runs straight after calibration. In the late ordering it rises at the end of calibration. The total time to ready is the same in both orderings.

A software re-reset request, taken any time the memory is out of reset, drops ready in the same cycle. It returns the pins to the reset state and repeats the whole sequence with every wait in full. The wait counts are parameters. Their defaults are 229,376 cycles for calibration and 65,536 cycles for lock.

Top module: `mem_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and through every cycle the memory is held in reset, `mem_rst` is 1, `mem_pll` is 0, `ready` is 0 and `busy` is 1.
- R2: With `hold_en`=1, `mem_rst` stays high for exactly max(C, S) cycles after the sequence starts. C is `cyc_per_ms`, with 0 treated as 1. S is the first cycle, counted from 1, in which `clk_stable` is seen high.
- R3: With `hold_en`=0, the one-millisecond pulse is skipped and `mem_rst` stays high for exactly S cycles.
- R4: `mem_rst` only falls on a clock edge at which `clk_stable` was high.
- R5: With `pll_early`=0 (sampled at reset release), `mem_pll` rises exactly CAL_CYC cycles after `mem_rst` falls.
- R6: With `pll_early`=1, `mem_pll` rises in the same cycle that `mem_rst` falls.
- R7: `ready` rises exactly CAL_CYC+LOCK_CYC cycles after `mem_rst` falls, in both orderings.
- R8: Whenever `ready` is 1, `mem_rst` is 0, `mem_pll` is 1 and `busy` is 0. While the sequence runs, `busy` is 1 and `ready` is 0.
- R9: When `rerst_req` is 1 while `mem_rst` is 0, `ready` is 0 in that same cycle. In the next cycle `mem_rst` is 1, `mem_pll` is 0 and `busy` is 1, and the full sequence of R2 to R7 follows.
- R10: `rerst_req` has no effect while `mem_rst` is high; the hold length of R2/R3 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset; starts the sequence |
| cyc_per_ms | input | MS_W | Clock cycles in one millisecond (0 acts as 1) |
| hold_en | input | 1 | 1: keep the memory in reset for one millisecond before release |
| pll_early | input | 1 | 1: raise PLL pin at reset release; 0: at end of calibration |
| clk_stable | input | 1 | Memory clocks are stable and within specification |
| rerst_req | input | 1 | Software request to re-run the sequence |
| mem_rst | output | 1 | Memory reset pin, active high |
| mem_pll | output | 1 | Memory PLL-enable pin |
| ready | output | 1 | Reads and writes are permitted |
| busy | output | 1 | Sequence in progress |

## Verification
`mem_rst` and `mem_pll` are decoded from registered state, so each changes one edge after the cycle that decides it. The bench counts whole intervals between falling edges, measuring the hold length, the position of the PLL rise and the position of the ready rise. It compares them with the closed-form counts max(C,S), 1 or CAL_CYC+1, and CAL_CYC+LOCK_CYC+1. The ready drop on a re-reset is combinational, so it is sampled 1 ns after the request is driven in the same interval. The pin changes are sampled at the next falling edge.

// File: rtl/mps_pkg.sv
// Package: shared types of the memory power-up sequencer.
// Assumes: nothing; types only.
package mps_pkg;

    // Sequencer phases: reset hold, calibration wait, lock wait, running.
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_CAL  = 2'd1,
        ST_LOCK = 2'd2,
        ST_RUN  = 2'd3
    } mps_state_t;

    // Which window length is loaded into the wait timer.
    typedef enum logic [1:0] {
        LD_MS   = 2'd0,
        LD_CAL  = 2'd1,
        LD_LOCK = 2'd2
    } mps_ld_t;

endpackage

// File: rtl/mps_timer.sv
// Module: mps_timer
// Loadable down-counter that saturates at zero and flags when it is there.
// Assumes: load_val holds the window length minus one; during rst_n low the
// caller presents the value to start from after reset.
module mps_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count register: load on reset or request, else step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Expiry flag.
    assign zero = (cnt == '0);

endmodule

// File: rtl/mps_fsm.sv
// Module: mps_fsm
// Phase controller: decides transitions, timer reloads and pin levels.
// Assumes: hold_en and cyc_per_ms are static while a sequence runs; the
// timer reports zero after exactly the loaded number of cycles.
module mps_fsm
    import mps_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold_en,
    input  logic    pll_early,
    input  logic    clk_stable,
    input  logic    rerst_req,
    input  logic    tmr_zero,
    output logic    tmr_ld,
    output mps_ld_t tmr_sel,
    output logic    tmr_dec,
    output logic    mem_rst,
    output logic    mem_pll,
    output logic    ready,
    output logic    busy
);

    mps_state_t state, state_nxt;
    logic       early_q;
    logic       hold_done;

    // The millisecond hold counts as done when it is bypassed or has expired.
    assign hold_done = !hold_en || tmr_zero;

    // Next-phase and timer-reload decision.
    always_comb begin
        state_nxt = state;
        tmr_ld    = 1'b0;
        tmr_sel   = LD_MS;
        unique case (state)
            ST_HOLD: begin
                if (hold_done && clk_stable) begin
                    state_nxt = ST_CAL;
                    tmr_ld    = 1'b1;
                    tmr_sel   = LD_CAL;
                end
            end
            ST_CAL: begin
                if (rerst_req) begin
                    state_nxt = ST_HOLD;
                    tmr_ld    = 1'b1;
                end else if (tmr_zero) begin
                    state_nxt = ST_LOCK;
                    tmr_ld    = 1'b1;
                    tmr_sel   = LD_LOCK;
                end
            end
            ST_LOCK: begin
                if (rerst_req) begin
                    state_nxt = ST_HOLD;
                    tmr_ld    = 1'b1;
                end else if (tmr_zero) begin
                    state_nxt = ST_RUN;
                end
            end
            default: begin
                if (rerst_req) begin
                    state_nxt = ST_HOLD;
                    tmr_ld    = 1'b1;
                end
            end
        endcase
    end

    // Phase register; block reset restarts at the reset hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    // Capture the PLL ordering at the moment the memory leaves reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q <= 1'b0;
        end else if (state == ST_HOLD && state_nxt == ST_CAL) begin
            early_q <= pll_early;
        end
    end

    // Pin and status decode from the registered phase.
    assign tmr_dec = (state != ST_RUN);
    assign mem_rst = (state == ST_HOLD);
    assign mem_pll = (state == ST_LOCK) || (state == ST_RUN) ||
                     ((state == ST_CAL) && early_q);
    assign busy    = (state != ST_RUN);
    assign ready   = (state == ST_RUN) && !rerst_req;

    // Running is only ever entered from the lock wait.
    AST_RUN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_LOCK)) // R7
        else $error("run entered without lock wait");

endmodule

// File: rtl/mem_pwrup_seq.sv
// Module: mem_pwrup_seq (top)
// Drives a synchronous memory's reset and PLL-enable pins through the
// power-up order: optional 1 ms reset pulse, release on stable clocks,
// calibration wait, PLL lock wait, then ready.
// Assumes: configuration inputs are static during a sequence; CAL_CYC and
// LOCK_CYC are at least 1.
module mem_pwrup_seq
    import mps_pkg::*;
#(
    parameter int MS_W     = 20,
    parameter int CAL_CYC  = 229376,
    parameter int LOCK_CYC = 65536
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MS_W-1:0] cyc_per_ms,
    input  logic            hold_en,
    input  logic            pll_early,
    input  logic            clk_stable,
    input  logic            rerst_req,
    output logic            mem_rst,
    output logic            mem_pll,
    output logic            ready,
    output logic            busy
);

    localparam int CAL_W  = $clog2(CAL_CYC + 1);
    localparam int LCK_W  = $clog2(LOCK_CYC + 1);
    localparam int WAIT_W = (CAL_W > LCK_W) ? CAL_W : LCK_W;
    localparam int CNT_W  = (WAIT_W > MS_W) ? WAIT_W : MS_W;

    localparam logic [CNT_W-1:0] CAL_LD  = CNT_W'(CAL_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LD = CNT_W'(LOCK_CYC - 1);

    logic             tmr_ld;
    logic             tmr_dec;
    logic             tmr_zero;
    mps_ld_t          tmr_sel;
    logic [CNT_W-1:0] ms_ld;
    logic [CNT_W-1:0] ld_val;

    // One-millisecond reload value, a zero setting acting as one cycle.
    assign ms_ld = (cyc_per_ms == '0) ? '0 : CNT_W'(cyc_per_ms - 1'b1);

    // Reload selection; block reset always primes the millisecond hold.
    always_comb begin
        if (!rst_n || tmr_sel == LD_MS) begin
            ld_val = ms_ld;
        end else if (tmr_sel == LD_CAL) begin
            ld_val = CAL_LD;
        end else begin
            ld_val = LOCK_LD;
        end
    end

    mps_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (ld_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    mps_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_en    (hold_en),
        .pll_early  (pll_early),
        .clk_stable (clk_stable),
        .rerst_req  (rerst_req),
        .tmr_zero   (tmr_zero),
        .tmr_ld     (tmr_ld),
        .tmr_sel    (tmr_sel),
        .tmr_dec    (tmr_dec),
        .mem_rst    (mem_rst),
        .mem_pll    (mem_pll),
        .ready      (ready),
        .busy       (busy)
    );

    AST_RDY_PINS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_pll && !mem_rst && !busy)) // R8
        else $error("ready with wrong pin state");

    AST_PLL_LOW_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rst |-> !mem_pll) // R1
        else $error("PLL pin high while memory in reset");

    AST_RELEASE_ON_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rst) |-> $past(clk_stable)) // R4
        else $error("reset released without stable clocks");

    AST_RERST_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rst && rerst_req) |=> (mem_rst && !mem_pll && busy)) // R9
        else $error("re-reset request not honoured");

    AST_RERST_IGNORED_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rst && rerst_req && !clk_stable) |=> mem_rst) // R10
        else $error("re-reset request disturbed the reset hold");

endmodule

// File: tb/mem_pwrup_seq_bench.sv
// Bench for mem_pwrup_seq: directed corners plus seeded random episodes,
// timing measured in whole clock intervals between falling edges.
module mem_pwrup_seq_bench;

    localparam int MS_W     = 8;
    localparam int CAL_CYC  = 37;
    localparam int LOCK_CYC = 23;
    localparam int WDOG     = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [MS_W-1:0] cyc_per_ms = '0;
    logic            hold_en = 1'b0;
    logic            pll_early = 1'b0;
    logic            clk_stable = 1'b0;
    logic            rerst_req = 1'b0;
    logic            mem_rst, mem_pll, ready, busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    mem_pwrup_seq #(
        .MS_W     (MS_W),
        .CAL_CYC  (CAL_CYC),
        .LOCK_CYC (LOCK_CYC)
    ) u_mem_pwrup_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_per_ms (cyc_per_ms),
        .hold_en    (hold_en),
        .pll_early  (pll_early),
        .clk_stable (clk_stable),
        .rerst_req  (rerst_req),
        .mem_rst    (mem_rst),
        .mem_pll    (mem_pll),
        .ready      (ready),
        .busy       (busy)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL R7 watchdog expired actual=%0d expected<%0d", cyc, WDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected reset hold length (R2, R3).
    function automatic int exp_hold(input int cpm, input bit hen, input int d);
        int c;
        c = (cpm < 1) ? 1 : cpm;
        if (!hen) return d + 1;
        return (c > d + 1) ? c : d + 1;
    endfunction

    // Called at the falling edge inside hold cycle 1. Measures the hold,
    // PLL rise and ready rise. abort_at>0 issues a re-reset at that
    // interval of the wait; returns at hold cycle 1 of the new sequence.
    task automatic track(input int cpm, input bit hen, input bit early, input int d,
                         input int ign_at, input int abort_at, output bit aborted);
        int hc;
        int i;
        int pll_at;
        int rdy_at;
        bit bad;
        aborted = 1'b0;
        hc  = 1;
        bad = 1'b0;
        clk_stable = (hc > d);
        rerst_req  = (ign_at == hc);
        while (hc < 600) begin
            @(negedge clk);
            if (!mem_rst) break;
            if (mem_pll || ready || !busy) bad = 1'b1;
            hc = hc + 1;
            clk_stable = (hc > d);
            rerst_req  = (ign_at == hc);
        end
        rerst_req = 1'b0;
        chk(bad == 1'b0, "R1", bad, 0);
        if (ign_at > 0)
            chk(hc == exp_hold(cpm, hen, d), "R10", hc, exp_hold(cpm, hen, d));
        else if (hen)
            chk(hc == exp_hold(cpm, hen, d), "R2", hc, exp_hold(cpm, hen, d));
        else
            chk(hc == exp_hold(cpm, hen, d), "R3", hc, exp_hold(cpm, hen, d));
        i = 1; pll_at = 0; rdy_at = 0; bad = 1'b0;
        while (i < 400) begin
            if (mem_rst) bad = 1'b1;
            if (mem_pll && pll_at == 0) pll_at = i;
            if (ready) begin
                if (!mem_pll || busy) bad = 1'b1;
                rdy_at = i;
                break;
            end
            if (!busy) bad = 1'b1;
            if (abort_at == i) begin
                rerst_req = 1'b1;
                @(negedge clk);
                chk(mem_rst && !mem_pll && busy && !ready, "R9",
                    {mem_rst, mem_pll, busy, ready}, 4'b1010);
                rerst_req = 1'b0;
                aborted = 1'b1;
                return;
            end
            @(negedge clk);
            i = i + 1;
        end
        chk(bad == 1'b0, "R8", bad, 0);
        if (early) chk(pll_at == 1, "R6", pll_at, 1);
        else       chk(pll_at == CAL_CYC + 1, "R5", pll_at, CAL_CYC + 1);
        chk(rdy_at == CAL_CYC + LOCK_CYC + 1, "R7", rdy_at, CAL_CYC + LOCK_CYC + 1);
    endtask

    // Block reset, check reset outputs, release; returns in hold cycle 1.
    task automatic por(input int cpm, input bit hen, input bit early);
        @(negedge clk);
        rst_n = 1'b0; clk_stable = 1'b0; rerst_req = 1'b0;
        cyc_per_ms = MS_W'(cpm); hold_en = hen; pll_early = early;
        repeat (3) @(negedge clk);
        chk(mem_rst && !mem_pll && !ready && busy, "R1",
            {mem_rst, mem_pll, ready, busy}, 4'b1001);
        rst_n = 1'b1;
    endtask

    // Re-reset from running: ready must fall in the same cycle.
    task automatic rerst_from_ready();
        rerst_req = 1'b1;
        #1;
        chk(ready == 1'b0, "R9", ready, 0);
        @(negedge clk);
        chk(mem_rst && !mem_pll && busy, "R9", {mem_rst, mem_pll, busy}, 3'b101);
        rerst_req = 1'b0;
    endtask

    initial begin
        bit ab;
        void'($urandom(32'd2718));
        // Directed corners.
        por(5, 1'b1, 1'b0);  track(5, 1'b1, 1'b0, 0, 0, 0, ab);
        por(4, 1'b1, 1'b1);  track(4, 1'b1, 1'b1, 10, 0, 0, ab);
        por(30, 1'b0, 1'b1); track(30, 1'b0, 1'b1, 3, 0, 0, ab);
        por(1, 1'b0, 1'b0);  track(1, 1'b0, 1'b0, 0, 0, 0, ab);
        por(0, 1'b1, 1'b0);  track(0, 1'b1, 1'b0, 0, 0, 0, ab);
        por(12, 1'b1, 1'b0); track(12, 1'b1, 1'b0, 20, 6, 0, ab);
        // Re-reset during calibration, then during lock, then from running.
        por(6, 1'b1, 1'b1);  track(6, 1'b1, 1'b1, 2, 0, 10, ab);
        track(6, 1'b1, 1'b1, 0, 0, CAL_CYC + 5, ab);
        track(6, 1'b1, 1'b1, 4, 0, 0, ab);
        rerst_from_ready();
        track(6, 1'b1, 1'b1, 0, 0, 0, ab);
        // Seeded random episodes.
        for (int k = 0; k < 12; k++) begin
            int cpm;
            bit hen;
            bit early;
            int d;
            int ab_at;
            cpm   = $urandom_range(0, 40);
            hen   = 1'($urandom_range(0, 1));
            early = 1'($urandom_range(0, 1));
            d     = $urandom_range(0, 45);
            ab_at = ($urandom_range(0, 3) == 0) ? $urandom_range(1, CAL_CYC + LOCK_CYC) : 0;
            por(cpm, hen, early);
            track(cpm, hen, early, d, ($urandom_range(0, 2) == 0) ? 2 : 0, ab_at, ab);
            if (ab) track(cpm, hen, early, $urandom_range(0, 45), 0, 0, ab);
            if ($urandom_range(0, 1) == 1) begin
                rerst_from_ready();
                track(cpm, hen, early, $urandom_range(0, 45), 0, 0, ab);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule